// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block collects overflow events for a small 8-bit processor core from two timer/event counters and one time base, and turns them into vectored call requests. Each source has a sticky request flag and its own enable bit. A single global enable gates all sources. When an enabled flag is pending, the global enable is on and the hardware call stack still has room, the block raises a registered request to the core. With it goes the index of the winning source and that source's fixed vector address.

The core answers with a one-cycle acknowledge and the index it served. On that acknowledge the block clears the served flag and the global enable, so the handler runs with further interrupts locked out until software turns the global enable back on. Only the program counter is saved by the core on entry. Status and working registers are the handler's responsibility. A separate wake-up output tells the core's power control that an enabled source is pending, whatever the global enable is.

Software reaches every enable and flag through a two-word register port. The request interface behaves as a valid/ready pair: `irq_req` is the valid, `irq_ack` is the ready. Once raised, the request, its index and its vector stay fixed until the acknowledge, with no time limit. After the acknowledge the request drops for at least one cycle.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle high on `ovf_pulse[i]` sets request flag i at the next clock edge. Flag bits read back at register address 1, bit i (0 = timer 0, 1 = timer 1, 2 = time base).
- R2: A request is raised only when the global enable, the source's enable and its flag are all set. A flag whose source or global enable is off stays set and raises no request.
- R3: While `stack_full` is high, no new request is raised, even with a flag and both enables set. Once it goes low, the pending request is raised at the next edge.
- R4: When several sources are eligible at once, the lowest index wins (timer 0, then timer 1, then time base). The vector is VEC_BASE + index*VEC_STEP, which gives 0x004, 0x008 and 0x00C by default.
- R5: `irq_req` is raised at the clock edge after the source becomes eligible. `irq_src` and `irq_vec` stay stable until the acknowledge. `irq_vec` reads zero while no request is raised.
- R6: An acknowledge clears only the flag named by `irq_ack_src`, clears the global enable, and drops `irq_req` at the same edge.
- R7: Writing register address 1 loads all flags from the write data. If an overflow pulse falls in the same cycle as a write that clears the same flag, the flag ends up set.
- R8: `wakeup` is high whenever any flag and its own enable are both set, regardless of the global enable.
- R9: Register address 0 holds the global enable in bit 0 and the source enables in bits 1 to 3 (timer 0, timer 1, time base). Unused bits of both registers read as zero.
- R10: After reset all flags and enables are clear, `irq_req` and `wakeup` are low, and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_pulse | input | 3 | Overflow pulses, one per source |
| stack_full | input | 1 | Core call stack has no free entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_req | output | 1 | Call request to the core (valid) |
| irq_src | output | 2 | Index of the requesting source |
| irq_vec | output | 11 | Vector address of the requesting source |
| irq_ack | input | 1 | One-cycle acknowledge from the core (ready) |
| irq_ack_src | input | 2 | Source index served by the core |
| wakeup | output | 1 | Enabled source pending, for leaving idle or sleep |

## Verification
Several rules are checked on every cycle by the bound checker. An overflow always leaves its flag set. A rising request always follows a cycle in which the global enable and a matching enabled flag were present. A full stack never lets a request start. A raised request holds its vector until acknowledged and drops right after. The vector is zero when idle. Only the bench scenarios can show the rest: which source wins a tie and the exact vector it carries, which flags an acknowledge leaves alone, the overflow-versus-software-clear race, the register layout, and wake-up while the global enable is off.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  // register select on the software port
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_FLAG = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NSRC  = 3,
  parameter int DW    = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  ovf,
  input  logic             ctrl_we,
  input  logic             flag_we,
  input  logic [DW-1:0]    wdata,
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_src,
  output logic             gie_q,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  flag_q
);
  logic [NSRC-1:0] flag_d;

  // write first, then acknowledge clear, then overflow set (overflow wins)
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      flag_d[i] = flag_we ? wdata[i] : flag_q[i];
      if (ack && (ack_src == IDX_W'(i))) flag_d[i] = 1'b0;
      if (ovf[i]) flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (ctrl_we) en_q <= wdata[NSRC:1];
      // entering a handler always locks out further requests
      if (ack)          gie_q <= 1'b0;
      else if (ctrl_we) gie_q <= wdata[0];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC  = 3,
  parameter int IDX_W = 2
) (
  input  logic [NSRC-1:0]  elig,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  // lowest index has highest priority: scan downward so it is written last
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_req_stage.sv
module irq_req_stage #(
  parameter int NSRC     = 3,
  parameter int IDX_W    = 2,
  parameter int VEC_W    = 11,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             found,
  input  logic [IDX_W-1:0] pick,
  input  logic             stack_full,
  input  logic             ack,
  output logic             req_q,
  output logic [IDX_W-1:0] src_q,
  output logic [VEC_W-1:0] vec_q
);
  localparam int NTAB = 1 << IDX_W;

  logic [VEC_W-1:0] vec_tab [NTAB];

  // one fixed vector per source slot
  for (genvar g = 0; g < NTAB; g++) begin : g_vec
    assign vec_tab[g] = VEC_W'(VEC_BASE + g * VEC_STEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
    end else if (req_q) begin
      if (ack) begin
        req_q <= 1'b0;
        src_q <= '0;
        vec_q <= '0;
      end
    end else if (found && !stack_full) begin
      req_q <= 1'b1;
      src_q <= pick;
      vec_q <= vec_tab[pick];
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC     = 3,
  parameter int DW       = 8,
  parameter int VEC_W    = 11,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  localparam int IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  ovf_pulse,
  input  logic             stack_full,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_src,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack,
  input  logic [IDX_W-1:0] irq_ack_src,
  output logic             wakeup
);
  import irq_vector_pkg::*;

  logic             gie_q;
  logic [NSRC-1:0]  en_q;
  logic [NSRC-1:0]  flag_q;
  logic [NSRC-1:0]  elig;
  logic             found;
  logic [IDX_W-1:0] pick;
  logic             ctrl_we;
  logic             flag_we;
  logic             ack_live;

  assign ctrl_we  = reg_wr && (reg_addr == REG_CTRL);
  assign flag_we  = reg_wr && (reg_addr == REG_FLAG);
  assign ack_live = irq_ack && irq_req;

  irq_flag_bank #(.NSRC(NSRC), .DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf     (ovf_pulse),
    .ctrl_we (ctrl_we),
    .flag_we (flag_we),
    .wdata   (reg_wdata),
    .ack     (ack_live),
    .ack_src (irq_ack_src),
    .gie_q   (gie_q),
    .en_q    (en_q),
    .flag_q  (flag_q)
  );

  assign elig = flag_q & en_q & {NSRC{gie_q}};

  irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .elig  (elig),
    .found (found),
    .pick  (pick)
  );

  irq_req_stage #(
    .NSRC(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .found      (found),
    .pick       (pick),
    .stack_full (stack_full),
    .ack        (ack_live),
    .req_q      (irq_req),
    .src_q      (irq_src),
    .vec_q      (irq_vec)
  );

  // wake-up ignores the global enable on purpose
  assign wakeup = |(flag_q & en_q);

  always_comb begin
    if (reg_addr == REG_CTRL) reg_rdata = DW'({en_q, gie_q});
    else                      reg_rdata = DW'(flag_q);
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NSRC  = 3,
  parameter int VEC_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  ovf_pulse,
  input logic             stack_full,
  input logic             irq_req,
  input logic             irq_ack,
  input logic [VEC_W-1:0] irq_vec,
  input logic             gie_q,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  flag_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    p_flag_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse[g] |=> flag_q[g]);
  end

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(gie_q && (|(en_q & flag_q))));

  p_stack_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && stack_full) |=> !irq_req);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  p_vec_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == '0));

  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> (!irq_req && !gie_q));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ovf_pulse  (ovf_pulse),
  .stack_full (stack_full),
  .irq_req    (irq_req),
  .irq_ack    (irq_ack),
  .irq_vec    (irq_vec),
  .gie_q      (gie_q),
  .en_q       (en_q),
  .flag_q     (flag_q)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ovf_pulse = '0;
  logic        stack_full = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_req;
  logic [1:0]  irq_src;
  logic [10:0] irq_vec;
  logic        irq_ack = 1'b0;
  logic [1:0]  irq_ack_src = '0;
  logic        wakeup;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .stack_full(stack_full),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_src(irq_src),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ack_src(irq_ack_src),
    .wakeup(wakeup)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic pulse(input logic [2:0] m);
    ovf_pulse = m;
    step();
    ovf_pulse = '0;
  endtask

  task automatic ack(input logic [1:0] s);
    irq_ack = 1'b1; irq_ack_src = s;
    step();
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 req", 32'(irq_req), 0);
    chk("R10 wakeup", 32'(wakeup), 0);
    rd_chk("R10 ctrl", 1'b0, 8'h00);
    rd_chk("R10 flags", 1'b1, 8'h00);
  endtask

  task automatic t_single();
    wr(1'b0, 8'b0000_0011);            // gie + timer 0 enable
    pulse(3'b001);
    rd_chk("R1 flag set", 1'b1, 8'h01);
    chk("R5 not yet raised", 32'(irq_req), 0);
    step();
    chk("R5 raised", 32'(irq_req), 1);
    chk("R4 vec t0", 32'(irq_vec), 32'h004);
    chk("R4 src t0", 32'(irq_src), 0);
    step(); step();
    chk("R5 held", 32'(irq_req), 1);
    chk("R5 vec held", 32'(irq_vec), 32'h004);
    ack(2'd0);
    chk("R6 req dropped", 32'(irq_req), 0);
    chk("R5 vec idle", 32'(irq_vec), 0);
    rd_chk("R6 flag cleared", 1'b1, 8'h00);
    rd_chk("R6 gie cleared", 1'b0, 8'b0000_0010);
  endtask

  task automatic t_mask();
    wr(1'b0, 8'b0000_0100);            // timer 1 enable, gie off
    pulse(3'b010);
    step(); step();
    chk("R2 no req without gie", 32'(irq_req), 0);
    rd_chk("R2 flag kept", 1'b1, 8'h02);
    chk("R8 wake without gie", 32'(wakeup), 1);
    wr(1'b0, 8'b0000_0101);
    step();
    chk("R2 raised after gie", 32'(irq_req), 1);
    chk("R4 vec t1", 32'(irq_vec), 32'h008);
    ack(2'd1);
    rd_chk("R6 flag1 cleared", 1'b1, 8'h00);
    wr(1'b0, 8'b0000_0001);            // gie only, time base masked
    pulse(3'b100);
    step(); step();
    chk("R2 masked src no req", 32'(irq_req), 0);
    chk("R8 no wake when masked", 32'(wakeup), 0);
    rd_chk("R2 masked flag kept", 1'b1, 8'h04);
    wr(1'b1, 8'h00);
    rd_chk("R7 sw clear", 1'b1, 8'h00);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_stack();
    stack_full = 1'b1;
    wr(1'b0, 8'b0000_0011);
    pulse(3'b001);
    step(); step(); step();
    chk("R3 blocked by stack", 32'(irq_req), 0);
    stack_full = 1'b0;
    step();
    chk("R3 raised after room", 32'(irq_req), 1);
    ack(2'd0);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_prio();
    wr(1'b0, 8'b0000_1111);
    pulse(3'b111);
    step();
    chk("R4 first t0", 32'(irq_vec), 32'h004);
    ack(2'd0);
    rd_chk("R6 only winner cleared", 1'b1, 8'h06);
    step();
    chk("R6 no req after ack", 32'(irq_req), 0);
    wr(1'b0, 8'b0000_1111);
    step();
    chk("R4 second t1", 32'(irq_vec), 32'h008);
    chk("R4 src t1", 32'(irq_src), 1);
    ack(2'd1);
    wr(1'b0, 8'b0000_1111);
    step();
    chk("R4 third tb", 32'(irq_vec), 32'h00C);
    chk("R4 src tb", 32'(irq_src), 2);
    ack(2'd2);
    rd_chk("R6 all cleared", 1'b1, 8'h00);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_sw_write();
    wr(1'b1, 8'b0000_0101);
    rd_chk("R7 sw set", 1'b1, 8'h05);
    reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h00; ovf_pulse = 3'b001;
    step();
    reg_wr = 1'b0; ovf_pulse = '0;
    rd_chk("R7 overflow wins", 1'b1, 8'h01);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_regmap();
    wr(1'b0, 8'hFF);
    rd_chk("R9 ctrl unused zero", 1'b0, 8'h0F);
    wr(1'b1, 8'hF8);
    rd_chk("R9 flag unused zero", 1'b1, 8'h00);
    wr(1'b0, 8'h00);
    rd_chk("R9 ctrl cleared", 1'b0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_mask();
    t_stack();
    t_prio();
    t_sw_write();
    t_regmap();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule